// File: doc/BRIEF.md
# Serial Flash Target Front End

This block sits between the four-wire serial pins of a page-organised flash device and its core controller. A falling chip select opens a frame and a rising chip select closes it. Bits on the serial input are taken on rising serial-clock edges, most significant bit first. The first eight bits form an opcode and the next twenty-four form an address. That address is split into a page number and a byte offset according to the page-size mode. The decoded request is offered to the core and held until the core acknowledges it.

For the read opcode, the block walks a read address through the array and shifts the addressed bytes out on falling serial-clock edges. For every other opcode, the bytes that follow the address are handed to the core one at a time. The serial pins are oversampled in the system clock domain, so both serial-clock idle levels work. A separate abort input returns the front end to idle at any time.

Top module: `sfe_top`

## Requirements
- R1: Serial-clock edges and serial-input bits are only taken between a falling and the next rising edge of `cs_n`; while `cs_n` is high no request and no write byte is produced.
- R2: After 32 rising serial-clock edges in a frame (8-bit opcode then 24-bit address, MSB first), `req_valid` rises with the opcode on `req_op`, and it stays high with all request fields stable until `req_ack` is seen.
- R3: In a read frame, `so` changes only after a falling serial-clock edge, and each byte goes out MSB first; the first data bit appears after the falling edge that follows the 32nd rising edge.
- R4: `so_oe` is low whenever `cs_n` is high (or `abort_n` is low) and high while the device is selected.
- R5: Both serial-clock idle levels are accepted: low (mode 0) and high (mode 3); a falling edge before the first rising edge of a frame has no effect.
- R6: With `page528` low, `req_page` is address bits [21:9] and `req_offs` is {0, address bits [8:0]}.
- R7: With `page528` high, `req_page` is address bits [22:10] and `req_offs` is address bits [9:0].
- R8: Opcode 0xE8 (parameter) is a read: the byte shown on `rd_page`/`rd_offs` advances by one after each output byte, wraps from offset 511 (512 mode) or 527 (528 mode) to offset 0 of the next page, and from page 8191 to page 0.
- R9: For any other opcode, every further 8 rising serial-clock edges give a one-cycle `wr_valid` pulse with the byte (MSB first) on `wr_byte`.
- R10: If `cs_n` rises before all 32 header bits have arrived, no request is issued.
- R11: While `abort_n` is low, a pending request is dropped and the frame is ended; after `abort_n` returns high, nothing is accepted until a new falling edge of `cs_n`.
- R12: `active` is high while the device is selected or while `busy` is high, including after `cs_n` rises during a busy operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| abort_n | input | 1 | Hardware abort, active low |
| page528 | input | 1 | Page-size mode: 0 = 512-byte pages, 1 = 528-byte pages |
| busy | input | 1 | Core is running a self-timed operation |
| req_ack | input | 1 | Core accepts the pending request |
| rd_data | input | 8 | Byte at `rd_page`/`rd_offs`, supplied by the core |
| so | output | 1 | Serial data out (valid when `so_oe` is high) |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |
| active | output | 1 | Device is not in standby |
| req_valid | output | 1 | A decoded request is pending |
| req_op | output | 8 | Opcode of the pending request |
| req_page | output | 13 | Page number of the pending request |
| req_offs | output | 10 | Byte offset of the pending request |
| wr_valid | output | 1 | One-cycle pulse: `wr_byte` holds a received data byte |
| wr_byte | output | 8 | Received data byte |
| rd_page | output | 13 | Page of the byte to be shifted out next |
| rd_offs | output | 10 | Offset of the byte to be shifted out next |

## Verification
On every cycle, the assertions check several properties. A pending request must hold still until it is acknowledged. The abort must clear the request, the read phase and the frame. A request may only rise inside a frame, and write bytes never appear during a read. The output bit may move only after a detected falling edge, and the end-of-page wrap must land on offset zero of the following page. Other behaviours can only be shown by the bench's scenarios. These include the address split in each page-size mode, the MSB-first byte order on the output, and the wrap across the last page under both clock idle levels. They also include the loss of a truncated header, the refusal to resume after an abort without a new chip-select fall, and the active output under busy.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  localparam int OP_W     = 8;
  localparam int ADDR_W   = 24;
  localparam int PAGE_W   = 13;
  localparam int OFFS_W   = 10;
  localparam int BYTE_W   = 8;
  localparam int HDR_BITS = OP_W + ADDR_W;
  localparam int SMALL_PAGE = 512;
  localparam int LARGE_PAGE = 528;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [PAGE_W-1:0] page;
    logic [OFFS_W-1:0] offs;
  } sfe_req_t;

  // Split a received header into opcode, page and offset for the page mode.
  function automatic sfe_req_t split_hdr(input logic [HDR_BITS-1:0] hdr,
                                         input logic wide);
    sfe_req_t r;
    r.op = hdr[HDR_BITS-1 -: OP_W];
    if (wide) begin
      r.page = hdr[OFFS_W +: PAGE_W];
      r.offs = hdr[0 +: OFFS_W];
    end else begin
      r.page = hdr[OFFS_W-1 +: PAGE_W];
      r.offs = {1'b0, hdr[0 +: OFFS_W-1]};
    end
    return r;
  endfunction

  function automatic logic [OFFS_W-1:0] last_offs(input logic wide);
    return wide ? OFFS_W'(LARGE_PAGE - 1) : OFFS_W'(SMALL_PAGE - 1);
  endfunction

endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int           W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] st1_q, st2_q, st3_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1_q[i] <= RST_VAL[i];
        st2_q[i] <= RST_VAL[i];
        st3_q[i] <= RST_VAL[i];
      end else begin
        st1_q[i] <= d[i];
        st2_q[i] <= st1_q[i];
        st3_q[i] <= st2_q[i];
      end
    end
    assign rise[i] = st2_q[i] & ~st3_q[i];
    assign fall[i] = ~st2_q[i] & st3_q[i];
  end

  assign q = st2_q;

endmodule

// File: rtl/sfe_rx.sv
module sfe_rx
  import sfe_pkg::*;
#(
  parameter logic [OP_W-1:0] RD_OP = 8'hE8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_q,
  input  logic              cs_q,
  input  logic              cs_fall,
  input  logic              sck_rise,
  input  logic              si_q,
  input  logic              page528,
  input  logic              req_ack,
  output logic              req_valid,
  output sfe_req_t          req,
  output logic              rd_start,
  output logic              rd_phase,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_byte
);

  localparam int CNT_W  = $clog2(HDR_BITS + 1);
  localparam int DCNT_W = $clog2(BYTE_W);

  logic                armed_q, armed_d;
  logic                hdr_q, hdr_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [HDR_BITS-1:0] sh_q, sh_d;
  logic                reqv_q, reqv_d;
  sfe_req_t            req_q, req_d;
  logic                rd_q, rd_d;
  logic                start_q, start_d;
  logic [DCNT_W-1:0]   dcnt_q, dcnt_d;
  logic [BYTE_W-1:0]   dsh_q, dsh_d;
  logic                wrv_q, wrv_d;
  logic [BYTE_W-1:0]   wrb_q, wrb_d;

  always_comb begin
    armed_d = armed_q;
    hdr_d   = hdr_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    reqv_d  = reqv_q;
    req_d   = req_q;
    rd_d    = rd_q;
    start_d = 1'b0;
    dcnt_d  = dcnt_q;
    dsh_d   = dsh_q;
    wrv_d   = 1'b0;
    wrb_d   = wrb_q;
    if (!abort_q) begin
      armed_d = 1'b0;
      hdr_d   = 1'b0;
      cnt_d   = '0;
      reqv_d  = 1'b0;
      rd_d    = 1'b0;
      dcnt_d  = '0;
    end else begin
      if (reqv_q && req_ack) begin
        reqv_d = 1'b0;
      end
      if (cs_fall) begin
        armed_d = 1'b1;
        hdr_d   = 1'b0;
        cnt_d   = '0;
        rd_d    = 1'b0;
        dcnt_d  = '0;
      end else if (cs_q) begin
        armed_d = 1'b0;
        rd_d    = 1'b0;
      end else if (armed_q && sck_rise) begin
        if (!hdr_q) begin
          sh_d  = {sh_q[HDR_BITS-2:0], si_q};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(HDR_BITS - 1)) begin
            hdr_d  = 1'b1;
            reqv_d = 1'b1;
            req_d  = split_hdr(sh_d, page528);
            if (req_d.op == RD_OP) begin
              rd_d    = 1'b1;
              start_d = 1'b1;
            end
          end
        end else if (!rd_q) begin
          dsh_d  = {dsh_q[BYTE_W-2:0], si_q};
          dcnt_d = dcnt_q + 1'b1;
          if (dcnt_q == DCNT_W'(BYTE_W - 1)) begin
            wrv_d = 1'b1;
            wrb_d = dsh_d;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      hdr_q   <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      reqv_q  <= 1'b0;
      req_q   <= '0;
      rd_q    <= 1'b0;
      start_q <= 1'b0;
      dcnt_q  <= '0;
      dsh_q   <= '0;
      wrv_q   <= 1'b0;
      wrb_q   <= '0;
    end else begin
      armed_q <= armed_d;
      hdr_q   <= hdr_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      reqv_q  <= reqv_d;
      req_q   <= req_d;
      rd_q    <= rd_d;
      start_q <= start_d;
      dcnt_q  <= dcnt_d;
      dsh_q   <= dsh_d;
      wrv_q   <= wrv_d;
      wrb_q   <= wrb_d;
    end
  end

  assign req_valid = reqv_q;
  assign req       = req_q;
  assign rd_start  = start_q;
  assign rd_phase  = rd_q;
  assign wr_valid  = wrv_q;
  assign wr_byte   = wrb_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    reqv_q && !req_ack && abort_q && !sck_rise |=> reqv_q && $stable(req_q)); // R2
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_q |=> !reqv_q && !rd_q && !armed_q); // R11
  AST_REQ_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reqv_q) |-> !$past(cs_q)); // R10
  AST_NO_WR_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    wrv_q |-> !rd_q); // R9

endmodule

// File: rtl/sfe_tx.sv
module sfe_tx
  import sfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAGE_W-1:0] ld_page,
  input  logic [OFFS_W-1:0] ld_offs,
  input  logic              fall,
  input  logic              rd_phase,
  input  logic              page528,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [PAGE_W-1:0] rd_page,
  output logic [OFFS_W-1:0] rd_offs,
  output logic              so_bit
);

  localparam int BIT_W = $clog2(BYTE_W);

  logic [PAGE_W-1:0] page_q, page_d;
  logic [OFFS_W-1:0] offs_q, offs_d;
  logic [BIT_W-1:0]  obit_q, obit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              so_q, so_d;
  logic [OFFS_W-1:0] last;

  assign last = last_offs(page528);

  always_comb begin
    page_d = page_q;
    offs_d = offs_q;
    obit_d = obit_q;
    sh_d   = sh_q;
    so_d   = so_q;
    if (load) begin
      page_d = ld_page;
      offs_d = ld_offs;
      obit_d = '0;
    end else if (fall && rd_phase) begin
      if (obit_q == '0) begin
        so_d = rd_data[BYTE_W-1];
        sh_d = {rd_data[BYTE_W-2:0], 1'b0};
      end else begin
        so_d = sh_q[BYTE_W-1];
        sh_d = {sh_q[BYTE_W-2:0], 1'b0};
      end
      obit_d = obit_q + 1'b1;
      if (obit_q == BIT_W'(BYTE_W - 1)) begin
        if (offs_q >= last) begin
          offs_d = '0;
          page_d = page_q + 1'b1;
        end else begin
          offs_d = offs_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      offs_q <= '0;
      obit_q <= '0;
      sh_q   <= '0;
      so_q   <= 1'b0;
    end else begin
      page_q <= page_d;
      offs_q <= offs_d;
      obit_q <= obit_d;
      sh_q   <= sh_d;
      so_q   <= so_d;
    end
  end

  assign rd_page = page_q;
  assign rd_offs = offs_q;
  assign so_bit  = so_q;

  AST_SO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(so_q)); // R3
  AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !load && fall && rd_phase && obit_q == BIT_W'(BYTE_W - 1) && offs_q == last
    |=> offs_q == '0 && page_q == $past(page_q) + 1'b1); // R8

endmodule

// File: rtl/sfe_top.sv
module sfe_top
  import sfe_pkg::*;
#(
  parameter logic [OP_W-1:0] RD_OP = 8'hE8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              abort_n,
  input  logic              page528,
  input  logic              busy,
  input  logic              req_ack,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              so,
  output logic              so_oe,
  output logic              active,
  output logic              req_valid,
  output logic [OP_W-1:0]   req_op,
  output logic [PAGE_W-1:0] req_page,
  output logic [OFFS_W-1:0] req_offs,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_byte,
  output logic [PAGE_W-1:0] rd_page,
  output logic [OFFS_W-1:0] rd_offs
);

  localparam int PIN_N   = 4;
  localparam int P_CS    = 0;
  localparam int P_SCK   = 1;
  localparam int P_SI    = 2;
  localparam int P_ABORT = 3;

  logic [PIN_N-1:0] pin_q, pin_rise, pin_fall;
  sfe_req_t         req;
  logic             rd_start, rd_phase, so_bit;

  sfe_sync #(
    .W       (PIN_N),
    .RST_VAL (PIN_N'(1) << P_CS)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({abort_n, si, sck, cs_n}),
    .q    (pin_q),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  sfe_rx #(.RD_OP(RD_OP)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort_q  (pin_q[P_ABORT]),
    .cs_q     (pin_q[P_CS]),
    .cs_fall  (pin_fall[P_CS]),
    .sck_rise (pin_rise[P_SCK]),
    .si_q     (pin_q[P_SI]),
    .page528  (page528),
    .req_ack  (req_ack),
    .req_valid(req_valid),
    .req      (req),
    .rd_start (rd_start),
    .rd_phase (rd_phase),
    .wr_valid (wr_valid),
    .wr_byte  (wr_byte)
  );

  sfe_tx u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (rd_start),
    .ld_page (req.page),
    .ld_offs (req.offs),
    .fall    (pin_fall[P_SCK]),
    .rd_phase(rd_phase),
    .page528 (page528),
    .rd_data (rd_data),
    .rd_page (rd_page),
    .rd_offs (rd_offs),
    .so_bit  (so_bit)
  );

  assign so_oe    = ~pin_q[P_CS] & pin_q[P_ABORT];
  assign so       = so_bit & so_oe;
  assign active   = ~pin_q[P_CS] | busy;
  assign req_op   = req.op;
  assign req_page = req.page;
  assign req_offs = req.offs;

  AST_SO_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pin_q[P_CS] && !rd_phase |=> !so_oe || $fell(pin_q[P_CS])); // R4

endmodule

// File: tb/sim_sfe_top.sv
module sim_sfe_top;
  import sfe_pkg::*;

  localparam int H = 8;
  localparam logic [7:0] RD = 8'hE8;
  localparam logic [7:0] WR = 8'h82;
  localparam int NV = 6;
  // {bytes[29:26], addr[25:2], page528[1], mode3[0]}
  localparam logic [29:0] VEC [NV] = '{
    {4'd3, 24'h000A03, 1'b0, 1'b0},
    {4'd4, 24'h3FFFFE, 1'b0, 1'b1},
    {4'd3, 24'h01920E, 1'b1, 1'b0},
    {4'd2, 24'h7FFE0F, 1'b1, 1'b1},
    {4'd2, 24'h2469FF, 1'b0, 1'b0},
    {4'd1, 24'h2AF155, 1'b1, 1'b0}
  };

  logic clk, rst_n, cs_n, sck, si, abort_n, page528, busy, req_ack;
  logic [7:0] rd_data;
  logic so, so_oe, active, req_valid, wr_valid;
  logic [7:0] req_op, wr_byte;
  logic [12:0] req_page, rd_page;
  logic [9:0] req_offs, rd_offs;

  int n_chk = 0, n_fail = 0, wr_cnt = 0;
  logic [7:0] wr_log [4];
  bit done = 0;

  function automatic logic [7:0] mem_byte(input logic [12:0] p, input logic [9:0] o);
    return o[7:0] ^ p[7:0] ^ {6'b0, o[9:8]} ^ {p[12:8], 3'b101};
  endfunction

  assign rd_data = mem_byte(rd_page, rd_offs);

  sfe_top u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .abort_n(abort_n), .page528(page528), .busy(busy), .req_ack(req_ack),
    .rd_data(rd_data), .so(so), .so_oe(so_oe), .active(active),
    .req_valid(req_valid), .req_op(req_op), .req_page(req_page),
    .req_offs(req_offs), .wr_valid(wr_valid), .wr_byte(wr_byte),
    .rd_page(rd_page), .rd_offs(rd_offs)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (wr_valid) begin
      if (wr_cnt < 4) wr_log[wr_cnt] <= wr_byte;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b, output logic o);
    sck = 1'b0;
    si  = b;
    waitn(H);
    o   = so;
    sck = 1'b1;
    waitn(H);
  endtask

  task automatic sbits(input logic [31:0] v, input int n);
    logic o;
    for (int i = n - 1; i >= 0; i--) sbit(v[i], o);
  endtask

  task automatic open_frame(input logic mode3);
    sck  = mode3;
    waitn(H);
    cs_n = 1'b0;
    waitn(H);
  endtask

  task automatic close_frame(input logic mode3);
    if (!mode3) begin
      sck = 1'b0;
      waitn(H);
    end
    cs_n = 1'b1;
    waitn(H);
  endtask

  task automatic ack;
    req_ack = 1'b1;
    waitn(1);
    req_ack = 1'b0;
    waitn(1);
  endtask

  task automatic run_read(input logic [29:0] v);
    logic mode3, p528;
    logic [23:0] a;
    logic [12:0] ep;
    logic [9:0] eo, last;
    logic [7:0] got;
    logic o;
    int nb;
    mode3 = v[0];
    p528  = v[1];
    a     = v[25:2];
    nb    = int'(v[29:26]);
    page528 = p528;
    if (p528) begin ep = a[22:10]; eo = a[9:0]; last = 10'd527; end
    else begin ep = a[21:9]; eo = {1'b0, a[8:0]}; last = 10'd511; end
    open_frame(mode3);
    chk("R4 oe while selected", so_oe, 1);
    chk("R12 active while selected", active, 1);
    sbits({RD, a}, 32);
    waitn(4);
    chk("R2 req_valid", req_valid, 1);
    chk("R2 req_op", req_op, RD);
    chk(p528 ? "R7 page" : "R6 page", req_page, ep);
    chk(p528 ? "R7 offs" : "R6 offs", req_offs, eo);
    for (int b = 0; b < nb; b++) begin
      got = '0;
      for (int k = 0; k < 8; k++) begin
        sbit(1'b0, o);
        got = {got[6:0], o};
      end
      chk(mode3 ? "R3 R5 R8 byte mode3" : "R3 R5 R8 byte mode0", got, mem_byte(ep, eo));
      if (eo >= last) begin eo = '0; ep = ep + 1'b1; end
      else eo = eo + 1'b1;
    end
    chk("R2 req held", req_valid, 1);
    close_frame(mode3);
    chk("R4 oe after deselect", so_oe, 0);
    ack();
    chk("R2 req cleared by ack", req_valid, 0);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; abort_n = 1'b1;
    page528 = 1'b0; busy = 1'b0; req_ack = 1'b0;
    waitn(5);
    rst_n = 1'b1;
    waitn(6);
    chk("R4 reset oe", so_oe, 0);
    chk("R2 reset req_valid", req_valid, 0);
    chk("R12 reset active", active, 0);

    for (int i = 0; i < NV; i++) run_read(VEC[i]);

    // R9 write data bytes
    page528 = 1'b0;
    open_frame(1'b0);
    sbits({WR, 24'h000C21}, 32);
    waitn(4);
    chk("R9 req_op write", req_op, WR);
    chk("R6 write page", req_page, 13'd6);
    chk("R6 write offs", req_offs, 10'h021);
    sbits(32'hA5, 8);
    sbits(32'h3C, 8);
    waitn(4);
    chk("R9 write count", wr_cnt, 2);
    chk("R9 write byte0", wr_log[0], 8'hA5);
    chk("R9 write byte1", wr_log[1], 8'h3C);
    close_frame(1'b0);
    ack();

    // R10 truncated header
    open_frame(1'b0);
    sbits({WR, 24'h00FFFF} >> 12, 20);
    close_frame(1'b0);
    waitn(4);
    chk("R10 no req on short frame", req_valid, 0);

    // R1 deselected traffic ignored
    for (int i = 0; i < 48; i++) begin
      logic o;
      sbit(1'b1, o);
    end
    sck = 1'b0;
    waitn(4);
    chk("R1 no req while deselected", req_valid, 0);
    chk("R1 no write while deselected", wr_cnt, 2);
    chk("R4 oe while deselected", so_oe, 0);

    // R11 abort
    open_frame(1'b0);
    sbits({WR, 24'h001234}, 32);
    waitn(4);
    chk("R11 req before abort", req_valid, 1);
    abort_n = 1'b0;
    waitn(6);
    chk("R11 req dropped", req_valid, 0);
    chk("R11 oe low in abort", so_oe, 0);
    abort_n = 1'b1;
    waitn(6);
    sbits({WR, 24'h004321}, 32);
    sbits(32'h77, 8);
    waitn(4);
    chk("R11 no req without new select", req_valid, 0);
    chk("R11 no write without new select", wr_cnt, 2);
    close_frame(1'b0);

    // R12 busy keeps active
    busy = 1'b1;
    waitn(2);
    chk("R12 active while busy", active, 1);
    busy = 1'b0;
    waitn(2);
    chk("R12 standby when idle", active, 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule